// File: doc/BRIEF.md
# Dual-Port Discrete I/O Controller

This block manages sixteen pins grouped into two 8-bit ports, E (pins 7..0) and F (pins 15..8). Each pin is handed to its bus-control function or kept as a general-purpose I/O pin, one pin at a time. A small register interface reaches three registers per port: a function-select register, a direction register and a data register. For every pin the block produces an output value and an output enable, and it receives the pin's level.

A pin given to bus control passes that function's output value and enable straight to the pin. An I/O pin drives its data latch when its direction bit selects output, and it is released otherwise. Bit 3 of port E has no pin. Its register bits have fixed values, and the block never drives it.

Top module: `discrete_io_ctrl`

## Requirements
- R1: After reset every function-select, direction and data-latch bit is 0. `pin_oe` is therefore 0, and the port E function-select register reads 0x08.
- R2: Address map. `reg_addr[2]` picks the port (0 = E, 1 = F) and `reg_addr[1:0]` picks the register: 0 = function select, 1 = direction, 2 = data. Register 3 reads 0x00 and writes to it change nothing.
- R3: A pin whose function-select bit is 1 drives `pin_out` from `bus_out` and `pin_oe` from `bus_oe`.
- R4: An I/O pin (function-select bit 0) with direction bit 1 has `pin_oe` = 1 and drives its data-latch value on `pin_out`.
- R5: An I/O pin with direction bit 0 has `pin_oe` = 0 and `pin_out` = 0.
- R6: The direction registers can be written and read back at any time, whatever the function-select settings.
- R7: A write to a data register updates the output latch even while the pin is an input. The latched value appears on the pin once the pin becomes an output.
- R8: A data-register read returns the latch bit where the direction bit is 1 and the `pin_in` level where it is 0.
- R9: Bit 3 of port E has fixed read-back values: 1 in function select, 0 in direction, 0 in data. Writes to it are ignored. `pin_oe[3]` and `pin_out[3]` are always 0.
- R10: A register write takes effect at the clock edge where `reg_wr` is high. Reads are combinational from the current address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (port, register) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| bus_out | input | 16 | Bus-control function output values, one per pin |
| bus_oe | input | 16 | Bus-control function output enables, one per pin |
| pin_in | input | 16 | Pin levels |
| pin_out | output | 16 | Value driven on each pin |
| pin_oe | output | 16 | Output enable for each pin |

## Verification
The main sweep writes a pseudo-random function-select, direction and data pattern to both ports, together with random `bus_out`, `bus_oe` and `pin_in` words. Over many iterations every pin sees all eight mixes of function, direction and latch, so pass-through pins, driven I/O pins and released I/O pins are all covered, along with the two sources of data read-back. Directed patterns cover the reset state and the unused register 3. They also load the latch while a pin is an input and then turn the pin to an output, which tells whether the latch follows writes or only follows the driven state. All-ones writes to the missing port E bit show whether its fixed values and idle pin hold.

// File: rtl/discrete_io_ctrl.sv
module discrete_io_ctrl #(
  parameter int PORT_W  = 8,
  parameter int GAP_BIT = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [2:0]            reg_addr,
  input  logic [PORT_W-1:0]     reg_wdata,
  output logic [PORT_W-1:0]     reg_rdata,
  input  logic [2*PORT_W-1:0]   bus_out,
  input  logic [2*PORT_W-1:0]   bus_oe,
  input  logic [2*PORT_W-1:0]   pin_in,
  output logic [2*PORT_W-1:0]   pin_out,
  output logic [2*PORT_W-1:0]   pin_oe
);
  localparam int NPIN = 2 * PORT_W;
  localparam logic [NPIN-1:0] GAP = NPIN'(1) << GAP_BIT;

  logic [NPIN-1:0] func_q, dir_q, lat_q;
  logic [NPIN-1:0] wr_word, wr_keep, rd_word, dat_rd;
  logic            hi;
  logic [1:0]      sel;

  assign hi  = reg_addr[2];
  assign sel = reg_addr[1:0];

  assign wr_word = hi ? {reg_wdata, {PORT_W{1'b0}}} : {{PORT_W{1'b0}}, reg_wdata};
  assign wr_keep = hi ? {{PORT_W{1'b0}}, {PORT_W{1'b1}}} : {{PORT_W{1'b1}}, {PORT_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      func_q <= '0;
      dir_q  <= '0;
      lat_q  <= '0;
    end else if (reg_wr) begin
      case (sel)
        2'd0:    func_q <= ((func_q & wr_keep) | wr_word) & ~GAP;
        2'd1:    dir_q  <= ((dir_q  & wr_keep) | wr_word) & ~GAP;
        2'd2:    lat_q  <= ((lat_q  & wr_keep) | wr_word) & ~GAP;
        default: ;
      endcase
    end
  end

  assign dat_rd = ((dir_q & lat_q) | (~dir_q & pin_in)) & ~GAP;

  always_comb begin
    case (sel)
      2'd0:    rd_word = func_q | GAP;
      2'd1:    rd_word = dir_q;
      2'd2:    rd_word = dat_rd;
      default: rd_word = '0;
    endcase
  end

  assign reg_rdata = hi ? rd_word[NPIN-1:PORT_W] : rd_word[PORT_W-1:0];

  assign pin_oe  = ((func_q & bus_oe)  | (~func_q & dir_q)) & ~GAP;
  assign pin_out = ((func_q & bus_out) | (~func_q & dir_q & lat_q)) & ~GAP;

  // R9
  gap_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe[GAP_BIT] && !pin_out[GAP_BIT] && !dir_q[GAP_BIT]);

  // R7
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd2) |=>
      lat_q[PORT_W-1:0] == ($past(reg_wdata) & ~GAP[PORT_W-1:0]));

  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && sel == 2'd1) |=> $stable(dir_q));

  // R5
  released_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~func_q & ~dir_q) == '0);

  // R2
  spare_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == 2'd3) |=> ($stable(func_q) && $stable(lat_q)));
endmodule

// File: tb/discrete_io_ctrl_tb.sv
module discrete_io_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic [15:0] bus_out = 0, bus_oe = 0, pin_in = 0;
  logic [15:0] pin_out, pin_oe;

  int checks = 0, errors = 0;
  logic [31:0] seed = 32'h1234_5678;
  localparam logic [15:0] GAP = 16'h0008;

  always #2.5 clk = ~clk;

  discrete_io_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_out(bus_out),
    .bus_oe(bus_oe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    logic [7:0] r;
    logic [15:0] fn, dr, lt, rb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", pin_oe, 16'h0000);
    rd(3'd0, r); chk("R1 E func", {8'h0, r}, 16'h0008);
    rd(3'd4, r); chk("R1 F func", {8'h0, r}, 16'h0000);
    rd(3'd1, r); chk("R1 E dir", {8'h0, r}, 16'h0000);
    rd(3'd5, r); chk("R1 F dir", {8'h0, r}, 16'h0000);

    // R7 latch loads while input, driven once output
    pin_in = 16'h0000;
    wr(3'd2, 8'hA5); wr(3'd6, 8'h5A);
    chk("R7 no drive while input", pin_oe, 16'h0000);
    rd(3'd2, r); chk("R8 E input reads pin", {8'h0, r}, 16'h0000);
    wr(3'd1, 8'hFF); wr(3'd5, 8'hFF);
    chk("R7 latch driven", pin_out, 16'h5AA5 & ~GAP);
    chk("R4 oe", pin_oe, 16'hFFFF & ~GAP);

    // R9 gap bit
    wr(3'd0, 8'hFF);
    rd(3'd0, r); chk("R9 E func", {8'h0, r}, 16'h00FF);
    wr(3'd0, 8'h00);
    rd(3'd0, r); chk("R9 E func wr0", {8'h0, r}, 16'h0008);
    rd(3'd1, r); chk("R9 E dir", {8'h0, r}, 16'h00F7);
    pin_in = 16'hFFFF;
    wr(3'd1, 8'h00);
    rd(3'd2, r); chk("R9 E data", {8'h0, r}, 16'h00F7);
    bus_out = 16'hFFFF; bus_oe = 16'hFFFF;
    wr(3'd0, 8'hFF); #1;
    chk("R9 gap oe", pin_oe & GAP, 16'h0000);
    chk("R9 gap out", pin_out & GAP, 16'h0000);

    // R2 spare register
    wr(3'd3, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd3, r); chk("R2 spare E", {8'h0, r}, 16'h0000);
    rd(3'd7, r); chk("R2 spare F", {8'h0, r}, 16'h0000);
    rd(3'd0, r); chk("R2 E func kept", {8'h0, r}, 16'h00FF);
    rd(3'd4, r); chk("R2 F func kept", {8'h0, r}, 16'h0000);

    // R3..R8, R10 sweep
    for (int it = 0; it < 300; it++) begin
      seed = nxt(seed); fn = seed[15:0]; dr = seed[31:16];
      seed = nxt(seed); lt = seed[15:0]; bus_out = seed[31:16];
      seed = nxt(seed); bus_oe = seed[15:0]; pin_in = seed[31:16];
      wr(3'd0, fn[7:0]); wr(3'd4, fn[15:8]);
      wr(3'd1, dr[7:0]); wr(3'd5, dr[15:8]);
      wr(3'd2, lt[7:0]); wr(3'd6, lt[15:8]);
      fn &= ~GAP; dr &= ~GAP; lt &= ~GAP;
      #1;
      chk("R3 R4 R5 pin_oe", pin_oe, ((fn & bus_oe) | (~fn & dr)) & ~GAP);
      chk("R3 R4 R5 pin_out", pin_out, ((fn & bus_out) | (~fn & dr & lt)) & ~GAP);
      rd(3'd0, r); rb[7:0] = r; rd(3'd4, r); rb[15:8] = r;
      chk("R10 func rb", rb, fn | GAP);
      rd(3'd1, r); rb[7:0] = r; rd(3'd5, r); rb[15:8] = r;
      chk("R6 dir rb", rb, dr);
      rd(3'd2, r); rb[7:0] = r; rd(3'd6, r); rb[15:8] = r;
      chk("R8 data rb", rb, ((dr & lt) | (~dr & pin_in)) & ~GAP);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule